// File: doc/BRIEF.md
# Operand Register Bank with Coded Load and Read Selects

This block is the small register bank of a byte-wide processor datapath. It keeps five 8-bit registers: an accumulator, the low and high bytes of an index register, and the low and high bytes of a stack pointer. Every register takes its write data from the ALU result bus (`z_bus`). A 3-bit write code picks which register captures that bus. A second, independent 3-bit read code picks which register feeds the ALU's left operand. Code 0 on either select means "no register".

The processor's cycle runs from one rising edge of `clk` to the next. All storage in the bank updates at the falling edge of `clk`, which is the middle of the cycle. A register write happens at that midpoint. At the same midpoint the bank also captures the selected register onto `left_val`, together with a flag that says a real register was selected. The read code is decoded combinationally and may glitch while it settles early in the cycle. Only its value at the midpoint matters. The captured operand then stays steady until the next midpoint.

Top module: `zbus_reg_bank`

## Requirements
- R1: While `rst_n` is low at a falling edge of `clk`, all five registers clear to 0x00, `left_val` clears to 0x00 and `left_vld` clears to 0.
- R2: At a falling edge of `clk` with `rst_n` high, write code 1, 2, 3, 4 or 5 loads `z_bus` into the accumulator, index low, index high, stack-pointer low or stack-pointer high, respectively.
- R3: Write codes 0, 6 and 7 leave all five registers unchanged.
- R4: A write changes only the one register its code names. The other four keep their values.
- R5: At each falling edge with `rst_n` high, a read code from 1 to 5 (same mapping as R2) captures that register's content into `left_val` and sets `left_vld` to 1. Both outputs then hold until the next falling edge.
- R6: Read codes 0, 6 and 7 capture 0x00 into `left_val` and 0 into `left_vld`.
- R7: When the same register is written and read at one falling edge, `left_val` shows the value it had before that write. The newly written value appears on `left_val` when the register is read at the following falling edge, one cycle later.
- R8: Changes of `rd_sel` between a rising edge and the next falling edge have no effect on `left_val`. Only the code present at the falling edge is used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock; storage updates on its falling edge (mid-cycle) |
| rst_n | input | 1 | Active-low reset, sampled at the falling edge |
| z_bus | input | 8 | ALU result bus, the write data for every register |
| wr_sel | input | 3 | Write code: 0 none, 1 acc, 2 index low, 3 index high, 4 SP low, 5 SP high, 6/7 none |
| rd_sel | input | 3 | Read code for the left operand, same mapping as `wr_sel` |
| left_val | output | 8 | Left-operand value captured at the last falling edge |
| left_vld | output | 1 | High when the captured value came from a real register |

## Verification
Every result appears one register stage after its stimulus, at the falling edge that follows the rising edge where the inputs were driven. The bench therefore drives the inputs just after a rising edge and compares the outputs one nanosecond after the next falling edge, well before the following rising edge. A write made at one midpoint is visible only through a read at the next midpoint. For that reason the bench's reference model computes the expected operand from its register copy as it stood before that cycle's write, and only then applies the write. The glitch case changes `rd_sel` inside the first half-cycle and expects the value chosen by the code that is present at the falling edge.

// File: rtl/zbus_reg_bank_pkg.sv
`timescale 1ns/1ps
package zbus_reg_bank_pkg;

  // Select codes shared by the write and read ports.
  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_ACC  = 3'd1,
    SEL_IXL  = 3'd2,
    SEL_IXH  = 3'd3,
    SEL_SPL  = 3'd4,
    SEL_SPH  = 3'd5
  } sel_code_e;

  // A code names a register when it lies in 1..slots.
  function automatic logic code_names_slot(input int code, input int slots);
    return (code >= 1) && (code <= slots);
  endfunction

endpackage

// File: rtl/zrb_sel_decode.sv
`timescale 1ns/1ps
module zrb_sel_decode #(
  parameter int CODE_W = 3,
  parameter int SLOTS  = 5
) (
  input  logic [CODE_W-1:0] code,
  output logic [SLOTS-1:0]  onehot,
  output logic              hit
);
  // Code g+1 selects slot g; code 0 and codes above SLOTS select nothing.
  for (genvar g = 0; g < SLOTS; g++) begin : g_dec
    assign onehot[g] = (code == CODE_W'(g + 1));
  end

  assign hit = |onehot;
endmodule

// File: rtl/zrb_slot.sv
`timescale 1ns/1ps
module zrb_slot #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  // Mid-cycle capture: falling edge of clk.
  always_ff @(negedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/zrb_left_latch.sv
`timescale 1ns/1ps
module zrb_left_latch #(
  parameter int DATA_W = 8,
  parameter int SLOTS  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SLOTS-1:0]        rd_onehot,
  input  logic                    rd_hit,
  input  logic [DATA_W*SLOTS-1:0] regs_flat,
  output logic [DATA_W-1:0]       left_val,
  output logic                    left_vld
);
  logic [DATA_W-1:0] mux_out;

  // AND-OR mux: no select gives all zeros.
  always_comb begin
    mux_out = '0;
    for (int i = 0; i < SLOTS; i++)
      mux_out = mux_out | (regs_flat[i*DATA_W +: DATA_W] & {DATA_W{rd_onehot[i]}});
  end

  // Capture at mid-cycle so early select glitches never reach the output.
  always_ff @(negedge clk) begin
    if (!rst_n) begin
      left_val <= '0;
      left_vld <= 1'b0;
    end else begin
      left_val <= mux_out;
      left_vld <= rd_hit;
    end
  end
endmodule

// File: rtl/zbus_reg_bank.sv
`timescale 1ns/1ps
module zbus_reg_bank #(
  parameter int DATA_W = 8,
  parameter int SLOTS  = 5,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] z_bus,
  input  logic [CODE_W-1:0] wr_sel,
  input  logic [CODE_W-1:0] rd_sel,
  output logic [DATA_W-1:0] left_val,
  output logic              left_vld
);
  localparam int FLAT_W = DATA_W * SLOTS;

  // Named internal events, visible to the bound checker.
  logic [SLOTS-1:0]  wr_onehot;
  logic              wr_hit;
  logic [SLOTS-1:0]  rd_onehot;
  logic              rd_hit;
  logic [FLAT_W-1:0] regs_flat;

  zrb_sel_decode #(.CODE_W(CODE_W), .SLOTS(SLOTS)) u_wr_dec (
    .code(wr_sel), .onehot(wr_onehot), .hit(wr_hit)
  );

  zrb_sel_decode #(.CODE_W(CODE_W), .SLOTS(SLOTS)) u_rd_dec (
    .code(rd_sel), .onehot(rd_onehot), .hit(rd_hit)
  );

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    zrb_slot #(.DATA_W(DATA_W)) u_slot (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (wr_onehot[s]),
      .d    (z_bus),
      .q    (regs_flat[s*DATA_W +: DATA_W])
    );
  end

  zrb_left_latch #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_left (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_onehot(rd_onehot),
    .rd_hit   (rd_hit),
    .regs_flat(regs_flat),
    .left_val (left_val),
    .left_vld (left_vld)
  );
endmodule

// File: rtl/zbus_reg_bank_chk.sv
`timescale 1ns/1ps
module zbus_reg_bank_chk #(
  parameter int DATA_W = 8,
  parameter int SLOTS  = 5,
  parameter int CODE_W = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [CODE_W-1:0]       wr_sel,
  input logic [CODE_W-1:0]       rd_sel,
  input logic [SLOTS-1:0]        wr_onehot,
  input logic                    wr_hit,
  input logic [DATA_W*SLOTS-1:0] regs_flat,
  input logic [DATA_W-1:0]       left_val,
  input logic                    left_vld
);
  function automatic logic [DATA_W-1:0] pick(input logic [DATA_W*SLOTS-1:0] f,
                                             input logic [CODE_W-1:0] c);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int i = 0; i < SLOTS; i++)
      if (c == CODE_W'(i + 1)) r = f[i*DATA_W +: DATA_W];
    return r;
  endfunction

  function automatic logic in_range(input logic [CODE_W-1:0] c);
    return (c != '0) && (int'(c) <= SLOTS);
  endfunction

  // R1
  reset_clear_chk: assert property (@(negedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (left_val == '0 && !left_vld && regs_flat == '0));

  // R3
  bank_hold_chk: assert property (@(negedge clk) disable iff (!rst_n)
    ($past(rst_n) && !in_range($past(wr_sel))) |-> regs_flat == $past(regs_flat));

  // R4
  wr_onehot_chk: assert property (@(negedge clk) disable iff (!rst_n)
    $onehot0(wr_onehot) && (wr_hit == in_range(wr_sel)));

  // R2
  wr_lands_chk: assert property (@(negedge clk) disable iff (!rst_n)
    ($past(rst_n) && in_range($past(wr_sel))) |-> pick(regs_flat, $past(wr_sel)) == $past(pick_z));

  // R5
  left_sel_chk: assert property (@(negedge clk) disable iff (!rst_n)
    ($past(rst_n) && in_range($past(rd_sel))) |->
      (left_vld && left_val == pick($past(regs_flat), $past(rd_sel))));

  // R6
  left_none_chk: assert property (@(negedge clk) disable iff (!rst_n)
    ($past(rst_n) && !in_range($past(rd_sel))) |-> (!left_vld && left_val == '0));

  // Helper for R2: the value the write bus carried, taken from the bound top.
  logic [DATA_W-1:0] pick_z;
  assign pick_z = zbus_reg_bank.z_bus;
endmodule

bind zbus_reg_bank zbus_reg_bank_chk #(
  .DATA_W(DATA_W), .SLOTS(SLOTS), .CODE_W(CODE_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_sel   (wr_sel),
  .rd_sel   (rd_sel),
  .wr_onehot(wr_onehot),
  .wr_hit   (wr_hit),
  .regs_flat(regs_flat),
  .left_val (left_val),
  .left_vld (left_vld)
);

// File: tb/zbus_reg_bank_bench.sv
`timescale 1ns/1ps
module zbus_reg_bank_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] z_bus = 8'h00;
  logic [2:0] wr_sel = 3'd0;
  logic [2:0] rd_sel = 3'd0;
  logic [7:0] left_val;
  logic       left_vld;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] model [5];

  always #2.5 clk = ~clk;

  zbus_reg_bank u_zbus_reg_bank (
    .clk(clk), .rst_n(rst_n), .z_bus(z_bus),
    .wr_sel(wr_sel), .rd_sel(rd_sel),
    .left_val(left_val), .left_vld(left_vld)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // One cycle: drive after the rising edge, check after the falling edge.
  // glitch_rd is applied first, then replaced by rd before mid-cycle.
  task automatic step(input logic rn, input logic [2:0] w, input logic [2:0] r,
                      input logic [7:0] z, input logic use_glitch,
                      input logic [2:0] glitch_rd, input string tag);
    logic [7:0] exp_v;
    logic       exp_ok;
    @(posedge clk);
    #0.5;
    rst_n = rn; wr_sel = w; z_bus = z;
    rd_sel = use_glitch ? glitch_rd : r;
    if (use_glitch) begin
      #1.0;
      rd_sel = r;
    end
    if (!rn) begin
      exp_v = 8'h00; exp_ok = 1'b0;
      for (int i = 0; i < 5; i++) model[i] = 8'h00;
    end else begin
      exp_ok = (r >= 3'd1) && (r <= 3'd5);
      exp_v  = exp_ok ? model[r - 3'd1] : 8'h00;
      if (w >= 3'd1 && w <= 3'd5) model[w - 3'd1] = z;
    end
    @(negedge clk);
    #1.0;
    check({tag, " value"}, left_val, exp_v);
    check({tag, " valid"}, {7'd0, left_vld}, {7'd0, exp_ok});
  endtask

  task automatic read_all(input string tag);
    for (int c = 1; c <= 5; c++) step(1'b1, 3'd0, 3'(c), 8'h00, 1'b0, 3'd0, tag);
  endtask

  initial begin
    for (int i = 0; i < 5; i++) model[i] = 8'h00;
    // R1: reset state
    step(1'b0, 3'd1, 3'd1, 8'h3C, 1'b0, 3'd0, "R1 reset");
    step(1'b0, 3'd2, 3'd2, 8'h3C, 1'b0, 3'd0, "R1 reset");
    read_all("R1 regs after reset");

    // R2: each code loads its own register, R4 others untouched
    for (int c = 1; c <= 5; c++) begin
      step(1'b1, 3'(c), 3'd0, 8'(8'h10 * c + c), 1'b0, 3'd0, "R2 load");
      read_all("R2/R4 readback");
    end

    // R3: codes 0, 6, 7 write nothing
    step(1'b1, 3'd0, 3'd0, 8'hFF, 1'b0, 3'd0, "R3 code0");
    step(1'b1, 3'd6, 3'd6, 8'hEE, 1'b0, 3'd0, "R3/R6 code6");
    step(1'b1, 3'd7, 3'd7, 8'hDD, 1'b0, 3'd0, "R3/R6 code7");
    read_all("R3 readback");

    // R7: same-edge write and read, then next-cycle readback
    step(1'b1, 3'd1, 3'd1, 8'hA5, 1'b0, 3'd0, "R7 same edge old value");
    step(1'b1, 3'd0, 3'd1, 8'h00, 1'b0, 3'd0, "R7 next cycle new value");
    step(1'b1, 3'd5, 3'd5, 8'h5A, 1'b0, 3'd0, "R7 same edge sph");
    step(1'b1, 3'd0, 3'd5, 8'h00, 1'b0, 3'd0, "R7 next cycle sph");

    // R8: early glitches on the read select are ignored
    for (int g = 0; g < 8; g++)
      step(1'b1, 3'd0, 3'(1 + g % 5), 8'h00, 1'b1, 3'(7 - g), "R8 glitch");

    // Exhaustive sweep of write and read codes: R5/R6 operand, R2/R3/R4 model
    for (int w = 0; w < 8; w++)
      for (int r = 0; r < 8; r++)
        step(1'b1, 3'(w), 3'(r), 8'(w * 37 + r * 11 + 5), 1'b0, 3'd0,
             (r >= 1 && r <= 5) ? "R5 sweep" : "R6 sweep");
    read_all("R2/R3/R4 sweep readback");

    // R1: reset after activity clears everything
    step(1'b0, 3'd3, 3'd3, 8'h77, 1'b0, 3'd0, "R1 re-reset");
    read_all("R1 regs after re-reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule